// File: doc/BRIEF.md
# Watchdog Timer with Keyed Reload Access

This block is a watchdog timer attached to a simple byte-wide register bus. Software sets a 24-bit time-out value through three reload byte registers: an upper byte, a high byte and a low byte. It then enables the watchdog and services it with a refresh pulse before the count runs out. If the watchdog is not serviced in time, the block raises a one-cycle system reset request. If the device is in stop mode at that moment, it raises a stop-mode recovery request instead. In both cases it records the cause in sticky status flags.

The reload registers are protected by a lock state machine. To open the lock, software writes a two-byte key to the control address, 0x55 followed by 0xAA, as two consecutive writes. It must then write the reload bytes strictly in the order upper, high, low. Any bus write that is not the next expected step drops the lock back to its closed state. Completing the low byte also closes it. Key bytes written to the control address never modify the control bits.

The register bus is a plain single-cycle interface with no back-pressure. A write takes effect at the clock edge where `wr_en` is high. Read data is a combinational view of the addressed register. The refresh, tick and stop-mode inputs are plain control pins.

Top module: `watchdog_guard`

## Requirements
- R1: After reset, the control address reads 0x00, the reload addresses read the bytes of the RELOAD_INIT parameter (address 1 = bits 23:16, address 2 = bits 15:8, address 3 = bits 7:0), and both request outputs are low.
- R2: A write of 0x55 or 0xAA to address 0 leaves every control bit unchanged. Any other write to address 0 loads bit 0 (enable) and bit 1 (reset mode) from the written data.
- R3: A write of 0x55 to address 0 from the closed state, followed directly by a write of 0xAA to address 0, opens the lock. The next three writes, to addresses 1, 2 and 3 in that order, are each stored into the addressed reload byte.
- R4: Any write that is not the next expected step returns the lock to closed. A reload write made while closed, or out of order, is dropped and the register keeps its value.
- R5: Once the low byte (address 3) has been accepted, the lock is closed again. A further reload write needs a new key.
- R6: The counter loads the reload value {upper, high, low} when the enable bit changes from 0 to 1, and on every cycle in which `refresh` is high.
- R7: The counter counts only while enabled. On each enabled `tick`, a nonzero count decrements. A tick that finds the count at zero is a time-out and reloads the counter. Time-out therefore falls on the (R+1)th tick after a load with reload value R. While disabled, ticks never cause a time-out.
- R8: On a time-out with reset mode set and `stop_mode` low, `rst_req` is high for one cycle, in the cycle after the tick edge, and control bit 7 (watchdog flag) becomes 1.
- R9: On a time-out with reset mode set and `stop_mode` high, `stop_rec_req` pulses instead of `rst_req`, and control bits 7 and 6 (stop flag) both become 1.
- R10: On a time-out with reset mode clear, neither request pulses, and only bit 7 is set.
- R11: Reading address 0 with `rd_en` clears bits 7 and 6 at that clock edge. A time-out at the same edge wins and leaves its flags set.
- R12: `rdata` follows `addr` combinationally. The control register reads as {bit7 watchdog flag, bit6 stop flag, 4'b0, reset mode, enable}, and the reload addresses read their stored bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears status on address 0) |
| addr | input | 2 | Register address: 0 control, 1 upper, 2 high, 3 low |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| tick | input | 1 | Watchdog count enable pulse |
| refresh | input | 1 | Service command, reloads the counter |
| stop_mode | input | 1 | Device is in stop mode |
| rst_req | output | 1 | One-cycle system reset request |
| stop_rec_req | output | 1 | One-cycle stop-mode recovery request |

## Verification
A register write takes effect at the edge where it is driven, so its result is read back combinationally on `rdata` half a cycle later. The bench drives every input at the falling edge and samples at the following falling edge. A request pulse becomes visible after the same rising edge that consumes the tick which causes it. The bench therefore checks both request outputs at the falling edge after every single tick, and expects silence on the first R ticks and a pulse exactly on tick R+1. Flag clearing by a read and the win of a time-out at the same edge are also seen one edge later, so each is checked by a peek that does not itself clear anything.

// File: rtl/wdtg_pkg.sv
`timescale 1ns/1ps
package wdtg_pkg;
  localparam int BYTE_W = 8;
  localparam int N_RL   = 3;
  localparam int CNT_W  = BYTE_W * N_RL;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_UP   = 2'd1;
  localparam logic [1:0] A_HI   = 2'd2;
  localparam logic [1:0] A_LO   = 2'd3;

  localparam logic [BYTE_W-1:0] KEY_FIRST  = 8'h55;
  localparam logic [BYTE_W-1:0] KEY_SECOND = 8'hAA;

  typedef enum logic [2:0] {
    LK_IDLE,
    LK_KEYED,
    LK_UP,
    LK_HI,
    LK_LO
  } lock_e;
endpackage

// File: rtl/wdtg_lock.sv
`timescale 1ns/1ps
module wdtg_lock
  import wdtg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic              key_hit,
  output logic [N_RL-1:0]   rl_we
);
  lock_e state, nxt;

  always_comb begin
    nxt     = state;
    key_hit = 1'b0;
    rl_we   = '0;
    if (wr_en) begin
      nxt = LK_IDLE;
      unique case (addr)
        A_CTRL: begin
          if (wdata == KEY_FIRST) begin
            key_hit = 1'b1;
            if (state == LK_IDLE) nxt = LK_KEYED;
          end else if (wdata == KEY_SECOND) begin
            key_hit = 1'b1;
            if (state == LK_KEYED) nxt = LK_UP;
          end
        end
        A_UP: if (state == LK_UP) begin
          rl_we[0] = 1'b1;
          nxt      = LK_HI;
        end
        A_HI: if (state == LK_HI) begin
          rl_we[1] = 1'b1;
          nxt      = LK_LO;
        end
        A_LO: if (state == LK_LO) begin
          rl_we[2] = 1'b1;
          nxt      = LK_IDLE;
        end
        default: nxt = LK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= LK_IDLE;
    else        state <= nxt;
  end

  assert_relock_after_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rl_we[2] |=> (state == LK_IDLE));
  assert_one_reload_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rl_we));
  assert_closed_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LK_IDLE) |-> (rl_we == '0));
endmodule

// File: rtl/wdtg_regs.sv
`timescale 1ns/1ps
module wdtg_regs
  import wdtg_pkg::*;
#(
  parameter logic [CNT_W-1:0] RELOAD_INIT = 24'hFFFFFF
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              key_hit,
  input  logic [N_RL-1:0]   rl_we,
  input  logic              set_wdt,
  input  logic              set_stop,
  output logic [BYTE_W-1:0] rdata,
  output logic [CNT_W-1:0]  reload,
  output logic              enable,
  output logic              rmode,
  output logic              wdt_flag,
  output logic              en_load
);
  logic [1:0]                 ctrl_q;
  logic                       wdt_f, stop_f;
  logic [N_RL-1:0][BYTE_W-1:0] rl_pk;
  logic                       ctrl_wr, rd_clr;

  assign ctrl_wr = wr_en && (addr == A_CTRL) && !key_hit;
  assign rd_clr  = rd_en && (addr == A_CTRL);
  assign en_load = ctrl_wr && wdata[0] && !ctrl_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= 2'b00;
    else if (ctrl_wr) ctrl_q <= wdata[1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdt_f  <= 1'b0;
      stop_f <= 1'b0;
    end else begin
      if (set_wdt)     wdt_f <= 1'b1;
      else if (rd_clr) wdt_f <= 1'b0;
      if (set_stop)    stop_f <= 1'b1;
      else if (rd_clr) stop_f <= 1'b0;
    end
  end

  for (genvar i = 0; i < N_RL; i++) begin : g_byte
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= RELOAD_INIT[(N_RL-1-i)*BYTE_W +: BYTE_W];
      else if (rl_we[i]) q <= wdata;
    end
    assign rl_pk[i] = q;
    assign reload[(N_RL-1-i)*BYTE_W +: BYTE_W] = q;
  end

  always_comb begin
    unique case (addr)
      A_CTRL:  rdata = {wdt_f, stop_f, 4'b0000, ctrl_q};
      A_UP:    rdata = rl_pk[0];
      A_HI:    rdata = rl_pk[1];
      A_LO:    rdata = rl_pk[2];
      default: rdata = '0;
    endcase
  end

  assign enable   = ctrl_q[0];
  assign rmode    = ctrl_q[1];
  assign wdt_flag = wdt_f;

  assert_key_keeps_ctrl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    key_hit |=> $stable(ctrl_q));
  assert_read_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !set_wdt) |=> !wdt_f);
endmodule

// File: rtl/wdtg_count.sv
`timescale 1ns/1ps
module wdtg_count
  import wdtg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] reload,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;

  assign expire = enable && tick && !load && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (load)             cnt <= reload;
    else if (enable && tick)   cnt <= (cnt == '0) ? reload : cnt - 1'b1;
  end

  assert_load_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(reload)));
  assert_decrement_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && tick && !load && cnt != '0) |=> (cnt == CNT_W'($past(cnt) - 1'b1)));
  assert_hold_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !load) |=> $stable(cnt));
endmodule

// File: rtl/watchdog_guard.sv
`timescale 1ns/1ps
module watchdog_guard
  import wdtg_pkg::*;
#(
  parameter logic [CNT_W-1:0] RELOAD_INIT = 24'hFFFFFF
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       tick,
  input  logic       refresh,
  input  logic       stop_mode,
  output logic       rst_req,
  output logic       stop_rec_req
);
  logic             key_hit;
  logic [N_RL-1:0]  rl_we;
  logic [CNT_W-1:0] reload;
  logic             enable, rmode, wdt_flag, en_load, expire;
  logic             set_stop;
  logic             rst_q, stop_q;

  assign set_stop = expire && rmode && stop_mode;

  wdtg_lock u_lock (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .key_hit(key_hit), .rl_we(rl_we)
  );

  wdtg_regs #(.RELOAD_INIT(RELOAD_INIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .key_hit(key_hit), .rl_we(rl_we), .set_wdt(expire),
    .set_stop(set_stop), .rdata(rdata), .reload(reload), .enable(enable),
    .rmode(rmode), .wdt_flag(wdt_flag), .en_load(en_load)
  );

  wdtg_count u_count (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
    .load(en_load || refresh), .reload(reload), .expire(expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q  <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      rst_q  <= expire && rmode && !stop_mode;
      stop_q <= set_stop;
    end
  end

  assign rst_req      = rst_q;
  assign stop_rec_req = stop_q;

  assert_req_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_q && stop_q));
  assert_req_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |-> wdt_flag);
endmodule

// File: tb/test_watchdog_guard.sv
`timescale 1ns/1ps
module test_watchdog_guard;
  localparam logic [23:0] INIT = 24'hC0FFEE;

  logic       clk = 1'b0;
  logic       rst_n, wr_en, rd_en, tick, refresh, stop_mode;
  logic [1:0] addr;
  logic [7:0] wdata, rdata;
  logic       rst_req, stop_rec_req;
  int         checks = 0;
  int         failures = 0;

  always #2.5 clk = ~clk;

  watchdog_guard #(.RELOAD_INIT(INIT)) i_watchdog_guard (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tick(tick), .refresh(refresh),
    .stop_mode(stop_mode), .rst_req(rst_req), .stop_rec_req(stop_rec_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic look(input logic [1:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b0;
    #1 d = rdata;
  endtask

  task automatic load_reload(input logic [23:0] v);
    wr(2'd0, 8'h55); wr(2'd0, 8'hAA);
    wr(2'd1, v[23:16]); wr(2'd2, v[15:8]); wr(2'd3, v[7:0]);
  endtask

  task automatic one_tick(output logic r, output logic s);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    r = rst_req; s = stop_rec_req;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R1..: actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic r, s;
    int seen;
    rst_n = 1'b0; wr_en = 0; rd_en = 0; tick = 0; refresh = 0; stop_mode = 0;
    addr = 0; wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R12 reset view
    look(2'd0, d); chk("R1 ctrl", d, 8'h00);
    look(2'd1, d); chk("R1 upper", d, INIT[23:16]);
    look(2'd2, d); chk("R1 high", d, INIT[15:8]);
    look(2'd3, d); chk("R1 low", d, INIT[7:0]);
    chk("R1 reqs", {rst_req, stop_rec_req}, 0);

    // R4 closed write dropped
    wr(2'd1, 8'h12); look(2'd1, d); chk("R4 closed drop", d, INIT[23:16]);

    // R3 full sequence, R12 read back
    load_reload(24'h123456);
    look(2'd1, d); chk("R3 upper", d, 8'h12);
    look(2'd2, d); chk("R3 high", d, 8'h34);
    look(2'd3, d); chk("R3 low", d, 8'h56);

    // R5 relocked
    wr(2'd1, 8'h77); look(2'd1, d); chk("R5 relock", d, 8'h12);

    // R4 out-of-order
    wr(2'd0, 8'h55); wr(2'd0, 8'hAA); wr(2'd2, 8'h99); wr(2'd1, 8'h98);
    look(2'd2, d); chk("R4 order high", d, 8'h34);
    look(2'd1, d); chk("R4 order upper", d, 8'h12);

    // R4 interrupted key, R2 normal write
    wr(2'd0, 8'h55); wr(2'd0, 8'h02); wr(2'd0, 8'hAA); wr(2'd1, 8'h44);
    look(2'd1, d); chk("R4 interrupted", d, 8'h12);
    look(2'd0, d); chk("R2 plain write", d, 8'h02);

    // R2 key bytes keep ctrl
    wr(2'd0, 8'h55); look(2'd0, d); chk("R2 key1 keeps", d, 8'h02);
    wr(2'd0, 8'hAA); look(2'd0, d); chk("R2 key2 keeps", d, 8'h02);
    wr(2'd0, 8'h00);

    // R7 R8 R9 R10 R11 sweep
    for (int rv = 0; rv <= 6; rv++) begin
      for (int m = 0; m < 3; m++) begin
        load_reload(24'(rv));
        stop_mode = (m == 1);
        wr(2'd0, 8'h00);
        wr(2'd0, (m == 2) ? 8'h01 : 8'h03);
        for (int k = 1; k <= rv + 1; k++) begin
          one_tick(r, s);
          if (k <= rv) chk("R7 early tick quiet", {r, s}, 2'b00);
          else if (m == 0) chk("R8 reset pulse", {r, s}, 2'b10);
          else if (m == 1) chk("R9 stop pulse", {r, s}, 2'b01);
          else chk("R10 no request", {r, s}, 2'b00);
        end
        @(negedge clk);
        chk("R8 pulse one cycle", {rst_req, stop_rec_req}, 2'b00);
        look(2'd0, d);
        chk("R9 flags", d, {1'b1, (m == 1), 4'b0, (m != 2), 1'b1});
        rd(2'd0, d);
        look(2'd0, d);
        chk("R11 read clears", d[7:6], 2'b00);
        wr(2'd0, 8'h00);
        stop_mode = 1'b0;
      end
    end

    // R6 refresh reload, R7 periodic time-out
    load_reload(24'd5);
    wr(2'd0, 8'h03);
    seen = 0;
    for (int k = 0; k < 3; k++) begin one_tick(r, s); seen += r; end
    refresh = 1'b1; @(negedge clk); refresh = 1'b0;
    for (int k = 0; k < 5; k++) begin one_tick(r, s); seen += r; end
    chk("R6 refresh delays", seen, 0);
    one_tick(r, s); chk("R6 timeout after refresh", r, 1'b1);
    seen = 0;
    for (int k = 0; k < 5; k++) begin one_tick(r, s); seen += r; end
    chk("R7 reload quiet", seen, 0);
    one_tick(r, s); chk("R7 second period", r, 1'b1);

    // R7 disabled no time-out
    wr(2'd0, 8'h02);
    seen = 0;
    for (int k = 0; k < 20; k++) begin one_tick(r, s); seen += r + s; end
    chk("R7 disabled quiet", seen, 0);
    rd(2'd0, d);

    // R11 time-out wins over same-edge read
    load_reload(24'd0);
    wr(2'd0, 8'h03);
    addr = 2'd0; rd_en = 1'b1; tick = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; tick = 1'b0;
    look(2'd0, d); chk("R11 set wins", d[7], 1'b1);
    rd(2'd0, d);
    look(2'd0, d); chk("R11 later clear", d[7], 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule